// File: doc/BRIEF.md
# Class-Aware Issue Interlock

This block sits at the decode stage of an in-order, single-issue pipeline. It decides each cycle whether the instruction waiting in decode may issue. Every instruction has an operation class (floating-point ALU, load, store or integer), an optional destination register and up to two source registers. The unit records how far every recently issued producer still is from having its result ready. It holds a consumer back, inserting one bubble per held cycle, until the distance fits the consumer's own way of using the operand. The number of bubbles therefore depends on the producer class and the consumer class together, not on a single load-use rule.

Each register has a small countdown. Issuing a producer loads that countdown with the producer class latency. The countdown falls by one every cycle until it reaches zero. A source may be read once its countdown is no higher than the slack its use allows. Store data has a slack of one. Every other use, including the store address, has a slack of zero. The instruction slot right after an issued branch always executes. When decode has nothing to offer in that slot, the unit emits an explicit no-op. A flush empties all countdowns and drops any pending slot.

Top module: `issue_interlock`

## Requirements
- R1: A floating-point ALU result read by another floating-point ALU operation issued back to back costs exactly 3 bubbles. Class codes are FPALU=0, LOAD=1, STORE=2, INT=3.
- R2: A floating-point ALU result read as store data (the second source of a STORE) costs exactly 2 bubbles.
- R3: A loaded value read by a floating-point ALU operation costs 1 bubble. A loaded value read as store data costs none.
- R4: An integer result read by an integer operation costs no bubble.
- R5: The store address (the first source of a STORE) needs a fully drained countdown, so a load feeding it costs 1 bubble.
- R6: A newer write to a register replaces the older producer's countdown. A floating-point ALU write followed at once by an integer write to the same register lets a later floating-point reader issue without a bubble.
- R7: While an instruction is held, `stall` is 1 and `out_kind` is 2 (bubble). An issue shows `out_kind` 1 with `stall` 0. The held instruction issues first, so program order is preserved.
- R8: In the first cycle after a branch issues with no valid instruction in decode, `out_kind` is 3 (slot no-op), once only. A valid instruction in that slot issues normally and no no-op appears.
- R9: In a flush cycle `out_kind` is 0 (idle) and `stall` is 0. All countdowns return to zero and a pending slot no-op is dropped.
- R10: After reset `out_kind` is 0, `stall` is 0 and no register holds a countdown.
- R11: Idle cycles count toward the distance. A floating-point ALU producer, one idle cycle, then a floating-point ALU reader costs 2 bubbles.
- R12: A store does not write its destination field. A reader of that register issues without a bubble after the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Kills the decode instruction and clears all tracking |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_class | input | 2 | Operation class: 0 FPALU, 1 LOAD, 2 STORE, 3 INT |
| dec_branch | input | 1 | The INT instruction in decode is a branch (no register write) |
| dec_dst | input | 5 | Destination register |
| dec_src1 | input | 5 | First source (address for LOAD and STORE) |
| dec_src2 | input | 5 | Second source (data for STORE, unused by LOAD) |
| stall | output | 1 | Decode must hold its instruction this cycle |
| out_kind | output | 2 | 0 idle, 1 issue, 2 bubble, 3 slot no-op |
| issue_class | output | 2 | Class of the issuing instruction, 0 otherwise |
| issue_dst | output | 5 | Destination of the issuing instruction, 0 otherwise |
| issue_branch | output | 1 | Issuing instruction is a branch |

## Verification
The hardest state to reach from the ports is the branch delay slot meeting a starved decode, a second branch or a flush, because each needs an exact cycle alignment after the branch issues. Directed sequences place a branch, then an idle cycle, a valid instruction or a flush right behind it. Random streams with idle gaps, frequent branches and rare flushes cover the mixed cases. The store-data slack of exactly one count is reached by pairing each producer class with a store that reads it as data and as address.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [1:0] {
    CL_FPALU = 2'd0,
    CL_LOAD  = 2'd1,
    CL_STORE = 2'd2,
    CL_INT   = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    SL_IDLE   = 2'd0,
    SL_ISSUE  = 2'd1,
    SL_BUBBLE = 2'd2,
    SL_NOP    = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/ilk_countdown.sv
module ilk_countdown
  import ilk_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int AW      = 5,
  parameter int CW      = 2,
  parameter int LAT_FP  = 3,
  parameter int LAT_LD  = 1,
  parameter int LAT_INT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_idx,
  input  logic [1:0]          wr_cls,
  output logic [NREG*CW-1:0]  cnt_flat
);
  logic [CW-1:0] wr_lat;
  logic [CW-1:0] cnt_q [NREG];

  always_comb begin
    case (op_class_e'(wr_cls))
      CL_FPALU: wr_lat = CW'(LAT_FP);
      CL_LOAD:  wr_lat = CW'(LAT_LD);
      default:  wr_lat = CW'(LAT_INT);
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [CW-1:0] cnt_d;
    logic          hit;
    logic          cnt_en;

    assign hit = wr_en && (wr_idx == AW'(g));

    always_comb begin
      cnt_en = flush || hit || (cnt_q[g] != '0);
      if (flush)        cnt_d = '0;
      else if (hit)     cnt_d = wr_lat;
      else if (cnt_q[g] != '0) cnt_d = cnt_q[g] - CW'(1);
      else              cnt_d = cnt_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[g] <= '0;
      else if (cnt_en) cnt_q[g] <= cnt_d;
    end

    assign cnt_flat[g*CW +: CW] = cnt_q[g];

    // R11
    cnt_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !hit && cnt_q[g] != '0) |=> (cnt_q[g] == $past(cnt_q[g]) - CW'(1)));
  end

  // R6
  newest_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (cnt_q[$past(wr_idx)] == $past(wr_lat)));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_flat == '0));
endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int AW       = 5,
  parameter int CW       = 2,
  parameter int ST_SLACK = 1
) (
  input  logic [NREG*CW-1:0] cnt_flat,
  input  logic [1:0]         cls,
  input  logic [AW-1:0]      src1,
  input  logic [AW-1:0]      src2,
  output logic               hazard
);
  localparam logic [CW-1:0] SLACK = CW'(ST_SLACK);

  logic [CW-1:0] c1, c2;
  logic          use2;
  logic [CW-1:0] allow2;

  assign c1 = cnt_flat[src1*CW +: CW];
  assign c2 = cnt_flat[src2*CW +: CW];

  always_comb begin
    use2   = (op_class_e'(cls) != CL_LOAD);
    allow2 = (op_class_e'(cls) == CL_STORE) ? SLACK : '0;
    hazard = (c1 != '0) || (use2 && (c2 > allow2));
  end
endmodule

// File: rtl/ilk_slot.sv
module ilk_slot
  import ilk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       dec_valid,
  input  logic       dec_branch,
  input  logic       hazard,
  output logic [1:0] kind
);
  slot_kind_e k;
  logic       pend_q, pend_d, pend_en;

  always_comb begin
    if (flush)          k = SL_IDLE;
    else if (dec_valid) k = hazard ? SL_BUBBLE : SL_ISSUE;
    else if (pend_q)    k = SL_NOP;
    else                k = SL_IDLE;
  end

  always_comb begin
    pend_en = flush || (k == SL_ISSUE) || (k == SL_NOP);
    if (flush)              pend_d = 1'b0;
    else if (k == SL_ISSUE) pend_d = dec_branch;
    else                    pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign kind = k;

  // R8
  single_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k == SL_NOP) |=> (k != SL_NOP));
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int LAT_FP   = 3,
  parameter int LAT_LD   = 1,
  parameter int LAT_INT  = 0,
  parameter int ST_SLACK = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     dec_valid,
  input  logic [1:0]               dec_class,
  input  logic                     dec_branch,
  input  logic [$clog2(NREG)-1:0]  dec_dst,
  input  logic [$clog2(NREG)-1:0]  dec_src1,
  input  logic [$clog2(NREG)-1:0]  dec_src2,
  output logic                     stall,
  output logic [1:0]               out_kind,
  output logic [1:0]               issue_class,
  output logic [$clog2(NREG)-1:0]  issue_dst,
  output logic                     issue_branch
);
  localparam int AW     = $clog2(NREG);
  localparam int MAXLAT = (LAT_FP > LAT_LD) ? ((LAT_FP > LAT_INT) ? LAT_FP : LAT_INT)
                                            : ((LAT_LD > LAT_INT) ? LAT_LD : LAT_INT);
  localparam int CW     = (MAXLAT < 1) ? 1 : $clog2(MAXLAT + 1);

  logic [1:0]          sync_q;
  logic                rst_i_n;
  logic [NREG*CW-1:0]  cnt_flat;
  logic                hazard;
  logic [1:0]          kind;
  logic                issuing;
  logic                writes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  ilk_hazard #(.NREG(NREG), .AW(AW), .CW(CW), .ST_SLACK(ST_SLACK)) u_haz (
    .cnt_flat (cnt_flat),
    .cls      (dec_class),
    .src1     (dec_src1),
    .src2     (dec_src2),
    .hazard   (hazard)
  );

  ilk_slot u_slot (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .flush      (flush),
    .dec_valid  (dec_valid),
    .dec_branch (dec_branch),
    .hazard     (hazard),
    .kind       (kind)
  );

  assign issuing = (slot_kind_e'(kind) == SL_ISSUE);
  assign writes  = !dec_branch && (op_class_e'(dec_class) != CL_STORE);

  ilk_countdown #(
    .NREG(NREG), .AW(AW), .CW(CW),
    .LAT_FP(LAT_FP), .LAT_LD(LAT_LD), .LAT_INT(LAT_INT)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .flush    (flush),
    .wr_en    (issuing && writes),
    .wr_idx   (dec_dst),
    .wr_cls   (dec_class),
    .cnt_flat (cnt_flat)
  );

  assign stall        = dec_valid && !flush && hazard;
  assign out_kind     = kind;
  assign issue_class  = issuing ? dec_class : 2'd0;
  assign issue_dst    = issuing ? dec_dst : '0;
  assign issue_branch = issuing && dec_branch;

  // R7
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    stall |-> (slot_kind_e'(out_kind) == SL_BUBBLE));

  // R8
  slot_executes_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (issuing && dec_branch && !flush) |=> (flush || slot_kind_e'(out_kind) != SL_IDLE));

  // R9
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    flush |-> (slot_kind_e'(out_kind) == SL_IDLE && !stall));
endmodule

// File: tb/sim_issue_interlock.sv
module sim_issue_interlock;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, flush, dec_valid, dec_branch;
  logic [1:0] dec_class;
  logic [4:0] dec_dst, dec_src1, dec_src2;
  logic       stall, issue_branch;
  logic [1:0] out_kind, issue_class;
  logic [4:0] issue_dst;

  int n_tests = 0;
  int n_fail  = 0;
  int mcnt [32];
  bit mpend;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  issue_interlock u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dec_valid(dec_valid),
    .dec_class(dec_class), .dec_branch(dec_branch), .dec_dst(dec_dst),
    .dec_src1(dec_src1), .dec_src2(dec_src2), .stall(stall),
    .out_kind(out_kind), .issue_class(issue_class), .issue_dst(issue_dst),
    .issue_branch(issue_branch)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lat_of(int c);
    return (c == 0) ? 3 : (c == 1) ? 1 : 0;
  endfunction

  function automatic int exp_kind();
    int  allow2;
    bit  hz;
    if (flush) return 0;
    if (dec_valid) begin
      allow2 = (dec_class == 2) ? 1 : 0;
      hz = (mcnt[dec_src1] != 0) || (dec_class != 1 && mcnt[dec_src2] > allow2);
      return hz ? 2 : 1;
    end
    return mpend ? 3 : 0;
  endfunction

  task automatic model_step(int k);
    if (flush) begin
      foreach (mcnt[i]) mcnt[i] = 0;
      mpend = 0;
      return;
    end
    foreach (mcnt[i]) if (mcnt[i] != 0) mcnt[i]--;
    if (k == 1 && !dec_branch && dec_class != 2) mcnt[dec_dst] = lat_of(dec_class);
    if (k == 1) mpend = dec_branch;
    else if (k == 3) mpend = 0;
  endtask

  // One cycle: compare at the falling edge, advance the model at the rising edge.
  task automatic tick(output int k);
    k = exp_kind();
    @(negedge clk);
    chk("R7 kind", out_kind, k);
    chk("R7 stall", stall, (k == 2) ? 1 : 0);
    if (k == 1) chk("R7 issue_dst", issue_dst, dec_dst);
    @(posedge clk);
    model_step(k);
    #1;
  endtask

  task automatic run_instr(int c, bit br, int d, int s1, int s2, output int bub);
    int k;
    dec_valid = 1; dec_class = 2'(c); dec_branch = br;
    dec_dst = 5'(d); dec_src1 = 5'(s1); dec_src2 = 5'(s2);
    bub = 0;
    for (int i = 0; i < 20; i++) begin
      tick(k);
      if (k == 2) bub++;
      else break;
    end
    dec_valid = 0; dec_branch = 0;
  endtask

  task automatic idle(int n);
    int k;
    dec_valid = 0;
    for (int i = 0; i < n; i++) tick(k);
  endtask

  task automatic do_flush();
    int k;
    flush = 1; dec_valid = 0;
    tick(k);
    flush = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int b, k;
    void'($urandom(32'h1d2c3b4a));
    rst_n = 0; flush = 0; dec_valid = 0; dec_branch = 0;
    dec_class = 0; dec_dst = 0; dec_src1 = 0; dec_src2 = 0;
    foreach (mcnt[i]) mcnt[i] = 0;
    mpend = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 reset kind", out_kind, 0);
    chk("R10 reset stall", stall, 0);
    @(posedge clk); #1;
    rst_n = 1;
    idle(3);
    for (int r = 0; r < 4; r++) begin
      run_instr(0, 0, 20, r, r + 4, b);
      chk("R10 no countdown after reset", b, 0);
    end

    do_flush();
    run_instr(0, 0, 1, 0, 0, b);
    run_instr(0, 0, 2, 1, 0, b);
    chk("R1 fp->fp bubbles", b, 3);

    do_flush();
    run_instr(0, 0, 2, 0, 0, b);
    run_instr(2, 0, 0, 10, 2, b);
    chk("R2 fp->store data bubbles", b, 2);

    do_flush();
    run_instr(1, 0, 3, 0, 0, b);
    run_instr(0, 0, 9, 0, 3, b);
    chk("R3 load->fp bubbles", b, 1);
    do_flush();
    run_instr(1, 0, 4, 0, 0, b);
    run_instr(2, 0, 0, 10, 4, b);
    chk("R3 load->store data bubbles", b, 0);

    do_flush();
    run_instr(3, 0, 5, 0, 0, b);
    run_instr(3, 0, 6, 5, 5, b);
    chk("R4 int->int bubbles", b, 0);

    do_flush();
    run_instr(1, 0, 6, 0, 0, b);
    run_instr(2, 0, 0, 6, 10, b);
    chk("R5 load->store address bubbles", b, 1);

    do_flush();
    run_instr(0, 0, 7, 0, 0, b);
    run_instr(3, 0, 7, 0, 0, b);
    chk("R6 int write right after fp", b, 0);
    run_instr(0, 0, 8, 7, 0, b);
    chk("R6 newest producer rules", b, 0);

    do_flush();
    run_instr(0, 0, 8, 0, 0, b);
    idle(1);
    run_instr(0, 0, 9, 8, 0, b);
    chk("R11 idle cycle counts", b, 2);

    do_flush();
    run_instr(2, 0, 11, 0, 0, b);
    run_instr(0, 0, 12, 11, 11, b);
    chk("R12 store leaves dst alone", b, 0);

    do_flush();
    run_instr(3, 1, 0, 0, 0, b);
    dec_valid = 0;
    k = exp_kind();
    @(negedge clk);
    chk("R8 slot no-op", out_kind, 3);
    @(posedge clk); model_step(k); #1;
    idle(1);
    @(negedge clk);
    chk("R8 no-op only once", out_kind, 0);
    @(posedge clk); #1;
    run_instr(3, 1, 0, 0, 0, b);
    run_instr(3, 0, 13, 0, 0, b);
    chk("R8 filled slot issues", b, 0);
    @(negedge clk);
    chk("R8 no no-op after filled slot", out_kind, 0);
    @(posedge clk); #1;

    do_flush();
    run_instr(0, 0, 13, 0, 0, b);
    flush = 1;
    @(negedge clk);
    chk("R9 flush kind idle", out_kind, 0);
    chk("R9 flush stall low", stall, 0);
    @(posedge clk); model_step(0); #1;
    flush = 0;
    run_instr(0, 0, 14, 13, 13, b);
    chk("R9 flush clears countdown", b, 0);
    run_instr(3, 1, 0, 0, 0, b);
    do_flush();
    @(negedge clk);
    chk("R9 flush drops slot no-op", out_kind, 0);
    @(posedge clk); #1;

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 2) do_flush();
      else if (r < 17) idle(1 + $urandom % 2);
      else begin
        int c;
        c = $urandom % 4;
        run_instr(c, (c == 3) && ($urandom % 4 == 0), $urandom % 8, $urandom % 8,
                  $urandom % 8, b);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule